// File: doc/BRIEF.md
# RAM Module Control Register Interface

This block is the bus-side register file for an on-chip RAM module. It decodes two kinds of bus access. A register access goes to the control word, the base address word or the two signature result words. An array access is any other request, and it is passed to the array only when the address falls inside the array's mapped window and the requester has the right privilege.

The control word holds four fields. A stop bit gates the module clocks. A signature-enable bit drives the external signature engine. A done flag reports the engine's state and cannot be written. A privilege bit limits the array to supervisor requests. The base address word gives the upper 16 bits of the array start address. Software can write it once after reset, and only while the module runs. Any write to it, even a single byte, locks it until the next reset.

While the stop bit is set, only the stop bit can be reached. Requests to the other register words are not acknowledged, and they have no effect. A control write that changes the stop bit updates only the stop bit. Register requests are acknowledged one cycle after the request. Read data is presented in the same cycle as the acknowledge.

Top module: `ramctl_regs`

## Requirements
- R1: After reset, stop_o is 1, sig_en_o is 0, the privilege bit is 0, the base word is 0 and unlocked, and reg_ack_o is 0.
- R2: A control write (index 0) with byte enable bit 1 set, whose wdata bit 15 differs from the current stop bit, updates only the stop bit. Signature enable and privilege keep their values.
- R3: With stop at 0 and the stop bit unchanged, a control write with byte enable bit 1 loads signature enable from wdata bit 9 and privilege from bit 8. The control read value is {stop, 4'b0, sig_done_i, enable, privilege, 8'b0}. Reserved bits read 0. A write with only byte enable bit 0 changes nothing.
- R4: While stop is 1, requests to index 1, 2 or 3 get no acknowledge and have no effect. A control read returns only bit 15 set, with all other bits 0.
- R5: The first base write (index 1) with stop at 0 and any byte enable set stores the enabled bytes and sets the lock.
- R6: After the lock is set, base writes are acknowledged but ignored until reset.
- R7: A base write with only one byte enabled sets the lock. The other byte keeps its reset value of 0.
- R8: A base write while stop is 1 leaves the base word and the lock unchanged.
- R9: array_sel_o is high in the same cycle when req_i is 1, reg_sel_i is 0, the lock is set, addr_i[23:8] equals the base word, and either privilege is 0 or sv_i is 1.
- R10: With privilege at 1, an array request with sv_i at 0 leaves array_sel_o at 0.
- R11: A register read returns its data, with reg_ack_o, one cycle after the request. Index 2 returns sig_value_i[31:16] and index 3 returns sig_value_i[15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe |
| reg_sel_i | input | 1 | 1 = register access, 0 = array access |
| we_i | input | 1 | Write enable |
| reg_idx_i | input | 2 | Register word: 0 control, 1 base, 2 signature high, 3 signature low |
| be_i | input | 2 | Byte enables (bit 1 = bits 15:8) |
| wdata_i | input | 16 | Write data |
| sv_i | input | 1 | 1 = supervisor requester |
| addr_i | input | 24 | Array access address |
| sig_done_i | input | 1 | Signature engine done flag |
| sig_value_i | input | 32 | Signature engine result |
| reg_ack_o | output | 1 | Register access acknowledge, one cycle after the request |
| rdata_o | output | 16 | Register read data |
| array_sel_o | output | 1 | Array access granted |
| stop_o | output | 1 | Stop bit |
| sig_en_o | output | 1 | Signature enable |

## Verification
A lost or premature lock shows on the next base read as a changed word. It also shows at once on array_sel_o, which stops or starts firing for matching addresses. A wrong stop state shows on the next request to a non-control word, as a missing or unexpected acknowledge one cycle later. A wrong privilege bit shows in the same cycle as a user array request. A control write that leaks into the other fields shows on the next control read.

// File: rtl/ramctl_pkg.sv
package ramctl_pkg;
  localparam int DATA_W = 16;
  localparam int BE_W   = DATA_W / 8;
  typedef enum logic [1:0] {
    IDX_CTRL   = 2'd0,
    IDX_BASE   = 2'd1,
    IDX_SIG_HI = 2'd2,
    IDX_SIG_LO = 2'd3
  } reg_idx_e;
  localparam int BIT_STOP = 15;
  localparam int BIT_DONE = 10;
  localparam int BIT_EN   = 9;
  localparam int BIT_PRIV = 8;
endpackage

// File: rtl/ramctl_decode.sv
module ramctl_decode
  import ramctl_pkg::*;
(
  input  logic     req_i,
  input  logic     reg_sel_i,
  input  logic     we_i,
  input  reg_idx_e idx_i,
  input  logic     stop_i,
  output logic     acc_ok_o,
  output logic     ctrl_wr_o,
  output logic     base_wr_o
);
  // in stop only the control word is reachable
  assign acc_ok_o  = req_i & reg_sel_i & (~stop_i | (idx_i == IDX_CTRL));
  assign ctrl_wr_o = acc_ok_o & we_i & (idx_i == IDX_CTRL);
  assign base_wr_o = acc_ok_o & we_i & (idx_i == IDX_BASE);
endmodule

// File: rtl/ramctl_ctrl.sv
module ramctl_ctrl
  import ramctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              stop_o,
  output logic              sig_en_o,
  output logic              priv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_o   <= 1'b1;
      sig_en_o <= 1'b0;
      priv_o   <= 1'b0;
    end else if (wr_i && be_i[BE_W-1]) begin
      if (wdata_i[BIT_STOP] != stop_o) begin
        stop_o <= wdata_i[BIT_STOP];   // stop change masks other fields
      end else if (!stop_o) begin
        sig_en_o <= wdata_i[BIT_EN];
        priv_o   <= wdata_i[BIT_PRIV];
      end
    end
  end
endmodule

// File: rtl/ramctl_base.sv
module ramctl_base
  import ramctl_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BASE_W = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              req_i,
  input  logic              reg_sel_i,
  input  logic              sv_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BASE_W-1:0] base_o,
  output logic              lock_o,
  output logic              array_sel_o
);
  localparam int LANES = BASE_W / 8;
  logic wr_ok;
  assign wr_ok = wr_i & ~lock_o & (|be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lock_o <= 1'b0;
    else if (wr_ok) lock_o <= 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                base_o[g*8 +: 8] <= 8'h00;
      else if (wr_ok && be_i[g])  base_o[g*8 +: 8] <= wdata_i[g*8 +: 8];
    end
  end

  logic hit;
  assign hit         = lock_o & (addr_i[ADDR_W-1 -: BASE_W] == base_o);
  assign array_sel_o = req_i & ~reg_sel_i & hit & (~priv_i | sv_i);
endmodule

// File: rtl/ramctl_regs.sv
module ramctl_regs
  import ramctl_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SIG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              reg_sel_i,
  input  logic              we_i,
  input  logic [1:0]        reg_idx_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sig_done_i,
  input  logic [SIG_W-1:0]  sig_value_i,
  output logic              reg_ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              array_sel_o,
  output logic              stop_o,
  output logic              sig_en_o
);
  reg_idx_e          idx;
  logic              acc_ok, ctrl_wr, base_wr;
  logic              priv_q, base_lock;
  logic [DATA_W-1:0] base_q;
  logic [DATA_W-1:0] rd_word;

  assign idx = reg_idx_e'(reg_idx_i);

  ramctl_decode u_decode (
    .req_i     (req_i),
    .reg_sel_i (reg_sel_i),
    .we_i      (we_i),
    .idx_i     (idx),
    .stop_i    (stop_o),
    .acc_ok_o  (acc_ok),
    .ctrl_wr_o (ctrl_wr),
    .base_wr_o (base_wr)
  );

  ramctl_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ctrl_wr),
    .be_i     (be_i),
    .wdata_i  (wdata_i),
    .stop_o   (stop_o),
    .sig_en_o (sig_en_o),
    .priv_o   (priv_q)
  );

  ramctl_base #(.ADDR_W(ADDR_W), .BASE_W(DATA_W)) u_base (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (base_wr),
    .be_i        (be_i),
    .wdata_i     (wdata_i),
    .req_i       (req_i),
    .reg_sel_i   (reg_sel_i),
    .sv_i        (sv_i),
    .priv_i      (priv_q),
    .addr_i      (addr_i),
    .base_o      (base_q),
    .lock_o      (base_lock),
    .array_sel_o (array_sel_o)
  );

  always_comb begin
    rd_word = '0;
    unique case (idx)
      IDX_CTRL: begin
        rd_word[BIT_STOP] = stop_o;
        if (!stop_o) begin
          rd_word[BIT_DONE] = sig_done_i;
          rd_word[BIT_EN]   = sig_en_o;
          rd_word[BIT_PRIV] = priv_q;
        end
      end
      IDX_BASE:   rd_word = base_q;
      IDX_SIG_HI: rd_word = sig_value_i[SIG_W-1 -: DATA_W];
      IDX_SIG_LO: rd_word = sig_value_i[DATA_W-1:0];
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_ack_o <= 1'b0;
      rdata_o   <= '0;
    end else begin
      reg_ack_o <= acc_ok;
      rdata_o   <= (acc_ok && !we_i) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/ramctl_regs_chk.sv
module ramctl_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        reg_sel_i,
  input logic        we_i,
  input logic [1:0]  reg_idx_i,
  input logic [1:0]  be_i,
  input logic [15:0] wdata_i,
  input logic        sv_i,
  input logic        reg_ack_o,
  input logic        array_sel_o,
  input logic        stop_o,
  input logic        sig_en_o,
  input logic        priv_q,
  input logic        base_lock,
  input logic [15:0] base_q
);
  assert_stop_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && reg_sel_i && stop_o && reg_idx_i != 2'd0) |=> !reg_ack_o);

  assert_stop_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && reg_sel_i && we_i && reg_idx_i == 2'd0 && be_i[1] && wdata_i[15] != stop_o)
    |=> (stop_o != $past(stop_o)) && $stable(sig_en_o) && $stable(priv_q));

  assert_base_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_lock |=> $stable(base_q) && base_lock);

  assert_lock_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && reg_sel_i && we_i && reg_idx_i == 2'd1 && be_i != 2'b00 && !stop_o)
    |=> base_lock);

  assert_user_blocked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_q && !sv_i) |-> !array_sel_o);

  assert_no_unlocked_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_sel_o |-> (base_lock && req_i && !reg_sel_i));

  assert_read_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && reg_sel_i && !stop_o) |=> reg_ack_o);
endmodule

bind ramctl_regs ramctl_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .reg_sel_i   (reg_sel_i),
  .we_i        (we_i),
  .reg_idx_i   (reg_idx_i),
  .be_i        (be_i),
  .wdata_i     (wdata_i),
  .sv_i        (sv_i),
  .reg_ack_o   (reg_ack_o),
  .array_sel_o (array_sel_o),
  .stop_o      (stop_o),
  .sig_en_o    (sig_en_o),
  .priv_q      (priv_q),
  .base_lock   (base_lock),
  .base_q      (base_q)
);

// File: tb/ramctl_regs_bench.sv
`timescale 1ns/1ps
module ramctl_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, reg_sel_i = 1'b0, we_i = 1'b0, sv_i = 1'b0;
  logic [1:0]  reg_idx_i = 2'd0, be_i = 2'd0;
  logic [15:0] wdata_i = 16'h0;
  logic [23:0] addr_i = 24'h0;
  logic        sig_done_i = 1'b1;
  logic [31:0] sig_value_i = 32'hCAFE_1234;
  logic        reg_ack_o, array_sel_o, stop_o, sig_en_o;
  logic [15:0] rdata_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;   // 125 MHz

  ramctl_regs u_ramctl_regs (
    .clk_i, .rst_ni, .req_i, .reg_sel_i, .we_i, .reg_idx_i, .be_i, .wdata_i,
    .sv_i, .addr_i, .sig_done_i, .sig_value_i, .reg_ack_o, .rdata_o,
    .array_sel_o, .stop_o, .sig_en_o
  );

  // {sel, we, idx[2], be[2], wdata[16], sv, addr[24], exp_ack, exp_rd[16], exp_arr}
  typedef logic [64:0] vec_t;
  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    {1'b1,1'b0,2'd0,2'b11,16'h0000,1'b1,24'h0,      1'b1,16'h8000,1'b0}, // 0  R1 R4
    {1'b1,1'b0,2'd1,2'b11,16'h0000,1'b1,24'h0,      1'b0,16'h0000,1'b0}, // 1  R4
    {1'b1,1'b1,2'd1,2'b11,16'h1234,1'b1,24'h0,      1'b0,16'h0000,1'b0}, // 2  R8
    {1'b1,1'b1,2'd0,2'b11,16'h0300,1'b1,24'h0,      1'b1,16'h0000,1'b0}, // 3  R2
    {1'b1,1'b0,2'd0,2'b11,16'h0000,1'b1,24'h0,      1'b1,16'h0400,1'b0}, // 4  R2 R3
    {1'b0,1'b0,2'd0,2'b00,16'h0000,1'b1,24'h000012, 1'b0,16'h0000,1'b0}, // 5  R9
    {1'b1,1'b1,2'd0,2'b11,16'h0300,1'b1,24'h0,      1'b1,16'h0000,1'b0}, // 6  R3
    {1'b1,1'b0,2'd0,2'b11,16'h0000,1'b1,24'h0,      1'b1,16'h0700,1'b0}, // 7  R3
    {1'b1,1'b1,2'd1,2'b10,16'h12AB,1'b1,24'h0,      1'b1,16'h0000,1'b0}, // 8  R5 R7
    {1'b1,1'b0,2'd1,2'b11,16'h0000,1'b1,24'h0,      1'b1,16'h1200,1'b0}, // 9  R7 R8
    {1'b1,1'b1,2'd1,2'b11,16'h5678,1'b1,24'h0,      1'b1,16'h0000,1'b0}, // 10 R6
    {1'b1,1'b0,2'd1,2'b11,16'h0000,1'b1,24'h0,      1'b1,16'h1200,1'b0}, // 11 R6
    {1'b0,1'b0,2'd0,2'b00,16'h0000,1'b1,24'h120045, 1'b0,16'h0000,1'b1}, // 12 R9
    {1'b0,1'b0,2'd0,2'b00,16'h0000,1'b0,24'h120045, 1'b0,16'h0000,1'b0}, // 13 R10
    {1'b0,1'b0,2'd0,2'b00,16'h0000,1'b1,24'h130045, 1'b0,16'h0000,1'b0}, // 14 R9
    {1'b1,1'b1,2'd0,2'b11,16'h0000,1'b1,24'h0,      1'b1,16'h0000,1'b0}, // 15 R3
    {1'b0,1'b0,2'd0,2'b00,16'h0000,1'b0,24'h1200FF, 1'b0,16'h0000,1'b1}, // 16 R9
    {1'b1,1'b0,2'd2,2'b11,16'h0000,1'b0,24'h0,      1'b1,16'hCAFE,1'b0}, // 17 R11
    {1'b1,1'b0,2'd3,2'b11,16'h0000,1'b0,24'h0,      1'b1,16'h1234,1'b0}, // 18 R11
    {1'b1,1'b1,2'd0,2'b11,16'hFCFF,1'b1,24'h0,      1'b1,16'h0000,1'b0}, // 19 R2
    {1'b1,1'b0,2'd0,2'b11,16'h0000,1'b1,24'h0,      1'b1,16'h8000,1'b0}, // 20 R4
    {1'b1,1'b0,2'd2,2'b11,16'h0000,1'b1,24'h0,      1'b0,16'h0000,1'b0}, // 21 R4
    {1'b1,1'b1,2'd0,2'b11,16'h7A00,1'b1,24'h0,      1'b1,16'h0000,1'b0}, // 22 R2
    {1'b1,1'b0,2'd0,2'b11,16'h0000,1'b1,24'h0,      1'b1,16'h0400,1'b0}, // 23 R2
    {1'b1,1'b1,2'd0,2'b01,16'hFFFF,1'b1,24'h0,      1'b1,16'h0000,1'b0}, // 24 R3
    {1'b1,1'b0,2'd0,2'b11,16'h0000,1'b1,24'h0,      1'b1,16'h0400,1'b0}  // 25 R3
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input string req);
    @(negedge clk_i);
    req_i = 1'b1; reg_sel_i = v[64]; we_i = v[63]; reg_idx_i = v[62:61];
    be_i = v[60:59]; wdata_i = v[58:43]; sv_i = v[42]; addr_i = v[41:18];
    #1 check({req, " array_sel"}, {15'b0, array_sel_o}, {15'b0, v[0]});
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    check({req, " ack"}, {15'b0, reg_ack_o}, {15'b0, v[17]});
    if (v[64] && !v[63] && v[17]) check({req, " rdata"}, rdata_o, v[16:1]);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #20;
    check("R1 stop_o", {15'b0, stop_o}, 16'h1);
    check("R1 reg_ack_o", {15'b0, reg_ack_o}, 16'h0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VEC[i], $sformatf("vec%0d", i));

    // R3: enable bit reaches sig_en_o
    run_vec({1'b1,1'b1,2'd0,2'b11,16'h0200,1'b1,24'h0,1'b1,16'h0000,1'b0}, "R3 en");
    check("R3 sig_en_o", {15'b0, sig_en_o}, 16'h1);

    // R1: async reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    check("R1 stop after reset", {15'b0, stop_o}, 16'h1);
    check("R1 en after reset", {15'b0, sig_en_o}, 16'h0);
    check("R1 ack after reset", {15'b0, reg_ack_o}, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    run_vec({1'b1,1'b0,2'd0,2'b11,16'h0000,1'b1,24'h0,1'b1,16'h8000,1'b0}, "R1 ctrl");
    run_vec({1'b1,1'b1,2'd0,2'b11,16'h0000,1'b1,24'h0,1'b1,16'h0000,1'b0}, "R1 run");
    run_vec({1'b1,1'b0,2'd1,2'b11,16'h0000,1'b1,24'h0,1'b1,16'h0000,1'b0}, "R1 base");
    run_vec({1'b0,1'b0,2'd0,2'b00,16'h0000,1'b1,24'h000011,1'b0,16'h0000,1'b0}, "R1 unlocked");
    // R7: low byte only, relocks after reset
    run_vec({1'b1,1'b1,2'd1,2'b01,16'hFF33,1'b1,24'h0,1'b1,16'h0000,1'b0}, "R7 low");
    run_vec({1'b1,1'b0,2'd1,2'b11,16'h0000,1'b1,24'h0,1'b1,16'h0033,1'b0}, "R7 readback");
    run_vec({1'b0,1'b0,2'd0,2'b00,16'h0000,1'b0,24'h003399,1'b0,16'h0000,1'b1}, "R9 relocked");
    run_vec({1'b1,1'b1,2'd1,2'b10,16'hAA00,1'b1,24'h0,1'b1,16'h0000,1'b0}, "R6 high");
    run_vec({1'b1,1'b0,2'd1,2'b11,16'h0000,1'b1,24'h0,1'b1,16'h0033,1'b0}, "R6 readback");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule